// File: doc/BRIEF.md
# Timed UART Receive Holding Register

This block models the receive side of a UART peripheral at register level, without sampling a serial line. A test or system model offers a whole character on an injection port. If the receiver is enabled and idle, the block accepts the character and keeps it pending for exactly one character frame. The frame length in clock cycles is computed from a programmable baud divisor, a normal or double speed setting, and the frame format: character size, parity and stop bits.

When the frame time has elapsed, the pending character moves into the holding register. At the same edge the busy status drops, the receive-complete flag rises and a one-cycle completion strobe fires. An interrupt request follows the flag whenever the interrupt enable is set. A bus read returns the held character masked to the configured size. The read is destructive: it clears the held character and the flag.

Three write ports load the frame format, the control bits and the divisor. Reset selects 8-bit characters, one stop bit, no parity, normal speed, receiver and interrupt disabled, and a divisor of zero.

Top module: `uart_rx_hold`

## Requirements
- R1: Frame length N = (divisor × M + 1) × (1 + data bits + stop bits + parity bit), where M is 16 at normal speed and 8 with the double-speed control bit set. The flag rises at the N-th rising edge after the accepting edge. Format write bits: [2:0] size code, [3] parity enable, [4] two stop bits. Control write bits: [0] receiver enable, [1] interrupt enable, [2] double speed. The divisor is 12 bits wide.
- R2: `inj_accept` is low while a character is pending or while the receiver enable is clear. A refused request leaves busy, flag and read data unchanged.
- R3: An accepted request sets `rx_busy` from the next cycle on. A request offered in the cycle after acceptance is refused.
- R4: When the frame time elapses, the character is latched, `rx_busy` falls, `rx_flag` rises, and `rx_done` is high for exactly one cycle.
- R5: One cycle before completion, `rx_flag` is still low and `rx_busy` is still high.
- R6: `rd_data` is the held character ANDed with a size mask. Size code 0, 1, 2 and 3 give masks 0x1F, 0x3F, 0x7F and 0xFF. Codes 4 to 7 select 9-bit characters, with mask 0xFF.
- R7: A cycle with `rd_en` high clears the held character and the flag, so `rd_data` reads 0 afterwards.
- R8: `rx_irq` is high exactly when `rx_flag` and the interrupt enable are both set.
- R9: After reset, busy, flag, interrupt and read data are zero, and the character size is 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_we | input | 1 | Write strobe for the frame format register |
| fmt_wdata | input | 5 | Frame format: size code, parity, two stop bits |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 3 | Receiver enable, interrupt enable, double speed |
| div_we | input | 1 | Write strobe for the baud divisor |
| div_wdata | input | DIV_W | Baud divisor value |
| inj_valid | input | 1 | Request to inject a character |
| inj_data | input | 8 | Character to inject |
| inj_accept | output | 1 | Request accepted this cycle |
| rx_busy | output | 1 | A character is pending |
| rd_en | input | 1 | Destructive read of the holding register |
| rd_data | output | 8 | Held character, masked to size |
| rx_flag | output | 1 | Receive-complete flag |
| rx_irq | output | 1 | Interrupt request |
| rx_done | output | 1 | One-cycle completion strobe |

## Verification
The bench sweeps every size code from 5 to 9 bits, with parity on and off, one and two stop bits, normal and double speed, and three divisors. Each frame starts from a different character. Sampling one cycle before and at the predicted edge catches an off-by-one in the multiplier, the symbol count or the counter load. Reading characters whose upper bits are set separates the masks for each size. A second request in the cycle after acceptance, a request just before completion, and a request with the receiver disabled distinguish the two refusal causes. A run that writes no format register after reset shows that the default is 8 bits.

// File: rtl/uart_rx_pkg.sv
// Shared types and helpers for the timed UART receive holding register.
// Assumes: size codes 0..3 mean 5..8 bits, codes 4..7 mean 9 bits.
package uart_rx_pkg;

    localparam int DATA_W  = 8;
    localparam int MUL_NRM = 16;
    localparam int MUL_DBL = 8;
    localparam int SYM_MAX = 13;

    typedef struct packed {
        logic       two_stop;
        logic       parity;
        logic [2:0] size;
    } fmt_t;

    typedef struct packed {
        logic dbl;
        logic irq_en;
        logic rx_en;
    } ctl_t;

    localparam fmt_t FMT_RST = '{two_stop: 1'b0, parity: 1'b0, size: 3'd3};
    localparam ctl_t CTL_RST = '{dbl: 1'b0, irq_en: 1'b0, rx_en: 1'b0};

    // Number of data bits selected by a size code.
    function automatic int unsigned data_bits(input logic [2:0] code);
        return (code >= 3'd4) ? 9 : (32'(code) + 5);
    endfunction

endpackage

// File: rtl/rx_frame_len.sv
// Computes the character frame length in clock cycles from the divisor,
// the speed setting and the frame format. Purely combinational.
// Assumes CNT_W is wide enough for the largest divisor and frame.
module rx_frame_len
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int CNT_W = 20
) (
    input  logic [DIV_W-1:0] divisor,
    input  logic             dbl,
    input  fmt_t             fmt,
    output logic [CNT_W-1:0] frame_len
);

    logic [CNT_W-1:0] per_symbol;
    logic [CNT_W-1:0] symbols;

    // Cycles per symbol: divisor times multiplier plus one.
    always_comb begin
        if (dbl) per_symbol = (CNT_W'(divisor) << 3) + CNT_W'(1);
        else     per_symbol = (CNT_W'(divisor) << 4) + CNT_W'(1);
    end

    // Symbols per frame: start, data, stop and optional parity.
    always_comb begin
        symbols = CNT_W'(1) + CNT_W'(data_bits(fmt.size))
                + (fmt.two_stop ? CNT_W'(2) : CNT_W'(1))
                + (fmt.parity ? CNT_W'(1) : CNT_W'(0));
    end

    assign frame_len = CNT_W'(per_symbol * symbols);

endmodule

// File: rtl/rx_frame_timer.sv
// Down-counter that tracks one in-flight character. Loaded on start,
// decrements each cycle, flags expiry when it would reach zero.
// Assumes load_len is at least 2 (the shortest frame is 7 cycles).
module rx_frame_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_len,
    output logic             busy,
    output logic             expire,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    assign expire = busy && (cnt == CNT_W'(1));

    // Busy state and remaining cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= load_len;
        end else if (busy) begin
            cnt  <= cnt - CNT_W'(1);
            if (expire) busy <= 1'b0;
        end
    end

    // One-cycle completion strobe, aligned with the flag rising.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= expire;
    end

endmodule

// File: rtl/rx_data_hold.sv
// Pending and held character storage, receive-complete flag and the
// size mask applied on the read path. Completion wins over a read.
// Assumes start and expire never occur in the same cycle.
module rx_data_hold
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] start_data,
    input  logic              expire,
    input  logic              rd_en,
    input  logic [2:0]        size,
    output logic [DATA_W-1:0] rd_data,
    output logic              flag
);

    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] held_q;
    logic [DATA_W-1:0] mask;
    int unsigned       nbits;

    assign nbits = data_bits(size);

    // Per-bit mask: bit kept when its index is below the character size.
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        assign mask[b] = (b < nbits);
    end

    // Capture the character while it is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= '0;
        else if (start) pend_q <= start_data;
    end

    // Holding register and flag: set on expiry, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            flag   <= 1'b0;
        end else if (expire) begin
            held_q <= pend_q;
            flag   <= 1'b1;
        end else if (rd_en) begin
            held_q <= '0;
            flag   <= 1'b0;
        end
    end

    assign rd_data = held_q & mask;

endmodule

// File: rtl/uart_rx_hold.sv
// Top of the timed UART receive holding register: configuration
// registers, injection acceptance and interrupt request.
// Assumes a single clock domain and synchronous active-low reset.
module uart_rx_hold
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 12,
    localparam int CNT_W = $clog2((((2 ** DIV_W) - 1) * MUL_NRM + 1) * SYM_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_we,
    input  logic [4:0]        fmt_wdata,
    input  logic              ctl_we,
    input  logic [2:0]        ctl_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              inj_valid,
    input  logic [DATA_W-1:0] inj_data,
    output logic              inj_accept,
    output logic              rx_busy,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_flag,
    output logic              rx_irq,
    output logic              rx_done
);

    fmt_t             fmt_q;
    ctl_t             ctl_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] frame_len;
    logic             expire;

    // Configuration registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= FMT_RST;
            ctl_q <= CTL_RST;
            div_q <= '0;
        end else begin
            if (fmt_we) fmt_q <= fmt_t'(fmt_wdata);
            if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
            if (div_we) div_q <= div_wdata;
        end
    end

    // Accept only when enabled and no character is pending.
    assign inj_accept = inj_valid && ctl_q.rx_en && !rx_busy;

    rx_frame_len #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_len (
        .divisor   (div_q),
        .dbl       (ctl_q.dbl),
        .fmt       (fmt_q),
        .frame_len (frame_len)
    );

    rx_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (inj_accept),
        .load_len (frame_len),
        .busy     (rx_busy),
        .expire   (expire),
        .done     (rx_done)
    );

    rx_data_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (inj_accept),
        .start_data (inj_data),
        .expire     (expire),
        .rd_en      (rd_en),
        .size       (fmt_q.size),
        .rd_data    (rd_data),
        .flag       (rx_flag)
    );

    // Interrupt request follows the flag when enabled.
    assign rx_irq = rx_flag && ctl_q.irq_en;

endmodule

// File: rtl/uart_rx_hold_chk.sv
// Property checker for uart_rx_hold, attached by bind below.
module uart_rx_hold_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       inj_valid,
    input logic       inj_accept,
    input logic       rx_busy,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       rx_flag,
    input logic       rx_irq,
    input logic       rx_done,
    input logic       irq_en,
    input logic [2:0] size
);

    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |-> !inj_accept); // R2

    AST_ACCEPT_IMPLIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        inj_accept |-> inj_valid); // R2

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        inj_accept |=> rx_busy); // R3

    AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (!rx_busy && rx_flag)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done); // R4

    AST_FLAG_RISE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> rx_done); // R5

    AST_MASK_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 3'd0) |-> (rd_data[7:5] == 3'b000)); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rx_busy) |=> (!rx_flag && rd_data == 8'h00)); // R7

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == (rx_flag && irq_en)); // R8

endmodule

bind uart_rx_hold uart_rx_hold_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inj_valid  (inj_valid),
    .inj_accept (inj_accept),
    .rx_busy    (rx_busy),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rx_flag    (rx_flag),
    .rx_irq     (rx_irq),
    .rx_done    (rx_done),
    .irq_en     (ctl_q.irq_en),
    .size       (fmt_q.size)
);

// File: tb/tb_uart_rx_hold.sv
module tb_uart_rx_hold;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 12;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fmt_we = 1'b0;
    logic [4:0]       fmt_wdata = '0;
    logic             ctl_we = 1'b0;
    logic [2:0]       ctl_wdata = '0;
    logic             div_we = 1'b0;
    logic [DIV_W-1:0] div_wdata = '0;
    logic             inj_valid = 1'b0;
    logic [7:0]       inj_data = '0;
    logic             inj_accept;
    logic             rx_busy;
    logic             rd_en = 1'b0;
    logic [7:0]       rd_data;
    logic             rx_flag;
    logic             rx_irq;
    logic             rx_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_hold #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .fmt_we(fmt_we), .fmt_wdata(fmt_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .div_we(div_we), .div_wdata(div_wdata),
        .inj_valid(inj_valid), .inj_data(inj_data), .inj_accept(inj_accept),
        .rx_busy(rx_busy), .rd_en(rd_en), .rd_data(rd_data),
        .rx_flag(rx_flag), .rx_irq(rx_irq), .rx_done(rx_done)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [4:0] f, input logic [2:0] c, input int d, input bit do_fmt);
        fmt_we = do_fmt; fmt_wdata = f;
        ctl_we = 1'b1;   ctl_wdata = c;
        div_we = 1'b1;   div_wdata = DIV_W'(d);
        tick();
        fmt_we = 1'b0; ctl_we = 1'b0; div_we = 1'b0;
    endtask

    function automatic int frame_cycles(int size, int par, int stp, int dbl, int dv);
        int bits = (size >= 4) ? 9 : size + 5;
        int mul  = dbl ? 8 : 16;
        return (dv * mul + 1) * (1 + bits + (stp ? 2 : 1) + par);
    endfunction

    function automatic logic [7:0] mask_of(int size);
        case (size)
            0: return 8'h1F;
            1: return 8'h3F;
            2: return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    // Inject one character, check timing, completion, read-back and clear.
    task automatic run_frame(input int n, input logic [7:0] data, input logic [7:0] msk, input bit irq_en);
        inj_valid = 1'b1; inj_data = data;
        #1 check(inj_accept == 1'b1, "R3 accept when idle", inj_accept, 1);
        tick();
        check(rx_busy == 1'b1, "R3 busy after accept", rx_busy, 1);
        inj_data = ~data;
        #1 check(inj_accept == 1'b0, "R3 next-cycle request refused", inj_accept, 0);
        tick();
        inj_valid = 1'b0;
        repeat (n - 2) tick();
        check(rx_busy == 1'b1 && rx_flag == 1'b0, "R5 pending before frame end",
              {rx_busy, rx_flag}, 2);
        inj_valid = 1'b1;
        #1 check(inj_accept == 1'b0, "R2 refused while busy", inj_accept, 0);
        inj_valid = 1'b0;
        tick();
        check(rx_flag && !rx_busy && rx_done, "R1 R4 completion at frame edge",
              {rx_flag, rx_busy, rx_done}, 5);
        check(rx_irq == irq_en, "R8 irq with flag", rx_irq, irq_en);
        tick();
        check(rx_done == 1'b0, "R4 done is one cycle", rx_done, 0);
        rd_en = 1'b1;
        #1 check(rd_data == (data & msk), "R6 masked read", rd_data, data & msk);
        tick();
        rd_en = 1'b0;
        check(rd_data == 8'h00 && rx_flag == 1'b0, "R7 read clears", {rx_flag, rd_data}, 0);
        check(rx_irq == 1'b0, "R8 irq drops with flag", rx_irq, 0);
    endtask

    initial begin
        int idx = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        check(!rx_busy && !rx_flag && !rx_irq && !rx_done && rd_data == 0,
              "R9 reset state", {rx_busy, rx_flag, rx_irq, rx_done, rd_data}, 0);

        // R2: disabled receiver refuses and nothing changes.
        inj_valid = 1'b1; inj_data = 8'h5A;
        #1 check(inj_accept == 1'b0, "R2 refused while disabled", inj_accept, 0);
        tick();
        inj_valid = 1'b0;
        repeat (20) tick();
        check(!rx_busy && !rx_flag && rd_data == 0, "R2 no effect when disabled",
              {rx_busy, rx_flag, rd_data}, 0);

        // R9: default format is 8 bits, one stop, no parity.
        write_cfg(5'd0, 3'b001, 1, 1'b0);
        run_frame(frame_cycles(3, 0, 0, 0, 1), 8'hFF, 8'hFF, 1'b0);

        // R1 R6: sweep every format, speed and small divisor.
        for (int sz = 0; sz < 5; sz++)
            for (int par = 0; par < 2; par++)
                for (int stp = 0; stp < 2; stp++)
                    for (int dbl = 0; dbl < 2; dbl++)
                        for (int dv = 0; dv < 3; dv++) begin
                            bit ie = idx[0];
                            logic [7:0] d = 8'(8'hE5 + idx * 37);
                            write_cfg({stp[0], par[0], sz[2:0]}, {dbl[0], ie, 1'b1}, dv, 1'b1);
                            run_frame(frame_cycles(sz, par, stp, dbl, dv), d, mask_of(sz), ie);
                            idx++;
                        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule